// File: doc/BRIEF.md
# Complementary PWM Gate-Drive Synthesizer

This block drives the two switches of a half-bridge leg. A microcontroller shifts a settings word in over a three-wire serial link. The word holds a frequency word, a duty code and a dead-time count. A phase accumulator runs on the system clock and adds the frequency word on every cycle. Each rising edge of its top bit gives a one-cycle tick. The tick advances a 4-bit step counter, and one full turn of that counter (16 ticks) is one switching period. The counter is compared with the duty code to form a PWM level. A dead-time stage then splits that level into a high-side drive and a low-side drive that never overlap.

New settings wait in shadow storage. They take effect only at a period boundary, so a reprogram never cuts a period short or leaves a runt pulse. With a 50 MHz clock and a 24-bit accumulator, the switching frequency is 50e6·F/2^28. A frequency word from about 215 up to about 966,000 covers 40 Hz to 180 kHz. Words of 2^23 and above alias the tick and are not meaningful.

A synchronous halt input stops switching at once.

Top module: `cpwm_synth`

## Requirements
- R1: While `rst_n` is low, both `hi_drv` and `lo_drv` are low, and all settings (active and shadow) are zero.
- R2: Each of `sclk`, `sdata` and `sload` passes through a two-flop synchronizer. A rising edge of the synchronized `sclk` shifts the synchronized `sdata` into a 36-bit register, MSB first. A rising edge of the synchronized `sload` copies that register to the shadow settings. The field layout is: bits 35..12 frequency word F, bits 11..8 duty code D, bits 7..0 dead-time count T.
- R3: The accumulator adds the active F on every clock. Each 0-to-1 transition of its bit 23 is one tick. Every tick advances the step counter modulo 16, so the switching frequency is f_clk·F/2^24/16.
- R4: The PWM level is high while the step counter is below D. D = 0 keeps it low, and D = 15 keeps it high for the whole period.
- R5: `hi_drv` follows the PWM level and `lo_drv` follows its inverse. The two are never high in the same cycle.
- R6: After any change of the PWM level, both outputs are low for exactly T+1 clock cycles before the incoming output is asserted.
- R7: The shadow settings become active only when a tick moves the counter from 15 to 0, while `halt` is high, or while the active F is zero.
- R8: `halt` high drives both outputs low at the next clock edge and clears the accumulator and the step counter. Switching restarts from count 0 once `halt` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Synchronous stop: outputs low, accumulator and counter cleared |
| sclk | input | 1 | Serial shift clock (asynchronous, oversampled) |
| sdata | input | 1 | Serial data, MSB first |
| sload | input | 1 | Rising edge copies the shifted word to the shadow settings |
| hi_drv | output | 1 | High-side switch drive |
| lo_drv | output | 1 | Low-side switch drive |

## Verification
The hardest case to reach is a new setting that lands in the shadow storage in the middle of a period, while switching runs. It must then stay inactive until the counter wraps, and only then change the duty and dead time. The stimulus streams new words over the serial pins without pulsing `halt`. A per-cycle reference model predicts the exact wrap cycle from the accumulator arithmetic. High and low counts are also taken over whole periods at several frequency, duty and dead-time settings, including the duty codes 0 and 15 and a zero dead time.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int unsigned FREQ_W_DEF = 24;
    localparam int unsigned DUTY_W_DEF = 4;
    localparam int unsigned DEAD_W_DEF = 8;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cpwm_serial_rx.sv
module cpwm_serial_rx
    import cpwm_pkg::*;
#(
    parameter int unsigned FREQ_W = FREQ_W_DEF,
    parameter int unsigned DUTY_W = DUTY_W_DEF,
    parameter int unsigned DEAD_W = DEAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              sload,
    output logic [FREQ_W-1:0] shd_freq,
    output logic [DUTY_W-1:0] shd_duty,
    output logic [DEAD_W-1:0] shd_dead
);
    localparam int unsigned WORD_W = FREQ_W + DUTY_W + DEAD_W;
    localparam int unsigned EDGE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [EDGE_W-1:0]      ck;
        logic [EDGE_W-1:0]      ld;
        logic [SYNC_STAGES-1:0] dat;
        logic [WORD_W-1:0]      shift;
        logic [WORD_W-1:0]      shadow;
    } rx_t;

    rx_t st_q, st_d;
    logic ck_rise, ld_rise;

    always_comb begin
        st_d    = st_q;
        ck_rise = st_q.ck[EDGE_W-2] & ~st_q.ck[EDGE_W-1];
        ld_rise = st_q.ld[EDGE_W-2] & ~st_q.ld[EDGE_W-1];
        st_d.ck  = {st_q.ck[EDGE_W-2:0], sclk};
        st_d.ld  = {st_q.ld[EDGE_W-2:0], sload};
        st_d.dat = {st_q.dat[SYNC_STAGES-2:0], sdata};
        if (ck_rise) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], st_q.dat[SYNC_STAGES-1]};
        end
        if (ld_rise) begin
            st_d.shadow = st_q.shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shd_freq = st_q.shadow[WORD_W-1 -: FREQ_W];
    assign shd_duty = st_q.shadow[DEAD_W +: DUTY_W];
    assign shd_dead = st_q.shadow[DEAD_W-1:0];

    AST_SHADOW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(st_q.shadow)); // R2
endmodule

// File: rtl/cpwm_phase_acc.sv
module cpwm_phase_acc
    import cpwm_pkg::*;
#(
    parameter int unsigned FREQ_W = FREQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [FREQ_W-1:0] freq,
    output logic              tick
);
    typedef struct packed {
        logic [FREQ_W-1:0] acc;
        logic              msb_p;
    } acc_t;

    acc_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = st_q.acc[FREQ_W-1] & ~st_q.msb_p;
        if (halt) begin
            st_d = '0;
        end else begin
            st_d.acc   = st_q.acc + freq;
            st_d.msb_p = st_q.acc[FREQ_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    AST_HALT_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st_q.acc == '0)); // R8
endmodule

// File: rtl/cpwm_duty_gen.sv
module cpwm_duty_gen
    import cpwm_pkg::*;
#(
    parameter int unsigned FREQ_W = FREQ_W_DEF,
    parameter int unsigned DUTY_W = DUTY_W_DEF,
    parameter int unsigned DEAD_W = DEAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              tick,
    input  logic [FREQ_W-1:0] shd_freq,
    input  logic [DUTY_W-1:0] shd_duty,
    input  logic [DEAD_W-1:0] shd_dead,
    output logic [FREQ_W-1:0] act_freq,
    output logic [DEAD_W-1:0] act_dead,
    output logic              pwm
);
    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic [FREQ_W-1:0] freq;
        logic [DUTY_W-1:0] duty;
        logic [DEAD_W-1:0] dead;
    } dg_t;

    dg_t  st_q, st_d;
    logic wrap, take;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == '1);
        take = halt || (st_q.freq == '0) || wrap;
        pwm  = (st_q.duty == '1) || (st_q.cnt < st_q.duty);
        if (halt) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (take) begin
            st_d.freq = shd_freq;
            st_d.duty = shd_duty;
            st_d.dead = shd_dead;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_freq = st_q.freq;
    assign act_dead = st_q.dead;

    AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !tick) |=> $stable(st_q.cnt)); // R3
    AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !tick && st_q.freq != '0) |=> ($stable(st_q.duty) && $stable(st_q.dead) && $stable(st_q.freq))); // R7
    AST_HALT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st_q.cnt == '0)); // R8
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int unsigned DEAD_W = DEAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              pwm,
    input  logic [DEAD_W-1:0] dead,
    output logic              hi_drv,
    output logic              lo_drv
);
    typedef struct packed {
        logic              prev;
        logic [DEAD_W-1:0] gap;
        logic              hi;
        logic              lo;
    } db_t;

    db_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (halt) begin
            st_d = '0;
        end else if (pwm != st_q.prev) begin
            st_d.prev = pwm;
            st_d.gap  = dead;
            st_d.hi   = 1'b0;
            st_d.lo   = 1'b0;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
            st_d.hi  = 1'b0;
            st_d.lo  = 1'b0;
        end else begin
            st_d.hi = st_q.prev;
            st_d.lo = ~st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_drv = st_q.hi;
    assign lo_drv = st_q.lo;

    AST_NO_OVERLAP: assert property (@(posedge clk) !(hi_drv && lo_drv)); // R5
    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!hi_drv && !lo_drv)); // R8
    AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_drv) |-> !$past(lo_drv)); // R6
    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_drv) |-> !$past(hi_drv)); // R6
endmodule

// File: rtl/cpwm_synth.sv
module cpwm_synth
    import cpwm_pkg::*;
#(
    parameter int unsigned FREQ_W = FREQ_W_DEF,
    parameter int unsigned DUTY_W = DUTY_W_DEF,
    parameter int unsigned DEAD_W = DEAD_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic sclk,
    input  logic sdata,
    input  logic sload,
    output logic hi_drv,
    output logic lo_drv
);
    logic [FREQ_W-1:0] shd_freq, act_freq;
    logic [DUTY_W-1:0] shd_duty;
    logic [DEAD_W-1:0] shd_dead, act_dead;
    logic              tick, pwm;

    cpwm_serial_rx #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .DEAD_W(DEAD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
        .shd_freq(shd_freq), .shd_duty(shd_duty), .shd_dead(shd_dead)
    );

    cpwm_phase_acc #(.FREQ_W(FREQ_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .halt(halt), .freq(act_freq), .tick(tick)
    );

    cpwm_duty_gen #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .DEAD_W(DEAD_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick),
        .shd_freq(shd_freq), .shd_duty(shd_duty), .shd_dead(shd_dead),
        .act_freq(act_freq), .act_dead(act_dead), .pwm(pwm)
    );

    cpwm_deadband #(.DEAD_W(DEAD_W)) u_db (
        .clk(clk), .rst_n(rst_n), .halt(halt), .pwm(pwm), .dead(act_dead),
        .hi_drv(hi_drv), .lo_drv(lo_drv)
    );

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> (!hi_drv && !lo_drv)); // R1
endmodule

// File: tb/cpwm_synth_bench.sv
module cpwm_synth_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic sload = 1'b0;
    logic hi_drv, lo_drv;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_synth u_cpwm_synth (
        .clk(clk), .rst_n(rst_n), .halt(halt), .sclk(sclk), .sdata(sdata),
        .sload(sload), .hi_drv(hi_drv), .lo_drv(lo_drv)
    );

    // Behavioural reference model, advanced on every rising edge
    logic [2:0]  m_ck, m_ld;
    logic [1:0]  m_dt;
    logic [35:0] m_shift, m_shadow;
    int unsigned m_acc, m_f, m_duty, m_dead, m_cnt, m_gap;
    bit          m_msbp, m_prev, m_hi, m_lo;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ck = 0; m_ld = 0; m_dt = 0; m_shift = 0; m_shadow = 0;
            m_acc = 0; m_f = 0; m_duty = 0; m_dead = 0; m_cnt = 0; m_gap = 0;
            m_msbp = 0; m_prev = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit ck_r, ld_r, tk, wr, take, lvl, acc_top;
            logic [35:0] nshift, nshadow;
            ck_r = m_ck[1] && !m_ck[2];
            ld_r = m_ld[1] && !m_ld[2];
            nshift  = ck_r ? {m_shift[34:0], m_dt[1]} : m_shift;
            nshadow = ld_r ? m_shift : m_shadow;
            m_ck = {m_ck[1:0], sclk};
            m_ld = {m_ld[1:0], sload};
            m_dt = {m_dt[0], sdata};
            acc_top = ((m_acc >> 23) & 1) != 0;
            tk   = acc_top && !m_msbp;
            wr   = tk && (m_cnt == 15);
            take = halt || (m_f == 0) || wr;
            lvl  = (m_duty == 15) || (m_cnt < m_duty);
            if (halt) begin
                m_hi = 0; m_lo = 0; m_gap = 0; m_prev = 0;
            end else if (lvl != m_prev) begin
                m_hi = 0; m_lo = 0; m_gap = m_dead; m_prev = lvl;
            end else if (m_gap != 0) begin
                m_gap = m_gap - 1; m_hi = 0; m_lo = 0;
            end else begin
                m_hi = m_prev; m_lo = !m_prev;
            end
            if (halt) begin
                m_acc = 0; m_msbp = 0; m_cnt = 0;
            end else begin
                m_msbp = acc_top;
                m_acc = (m_acc + m_f) % (1 << 24);
                if (tk) m_cnt = (m_cnt + 1) % 16;
            end
            if (take) begin
                m_f    = m_shadow[35:12];
                m_duty = m_shadow[11:8];
                m_dead = m_shadow[7:0];
            end
            m_shift = nshift;
            m_shadow = nshadow;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (hi_drv !== m_hi || lo_drv !== m_lo) begin
                fails++;
                $display("FAIL R2 R3 R4 R6 R7 R8 per-cycle t=%0t: hi/lo=%b%b expected %b%b",
                         $time, hi_drv, lo_drv, m_hi, m_lo);
            end
            checks++;
            if (hi_drv && lo_drv) begin
                fails++;
                $display("FAIL R5 overlap t=%0t: hi/lo=%b%b expected not both 1", $time, hi_drv, lo_drv);
            end
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input int unsigned f, input int unsigned d, input int unsigned t);
        logic [35:0] w;
        w = {f[23:0], d[3:0], t[7:0]};
        for (int i = 35; i >= 0; i--) begin
            @(negedge clk); sdata = w[i];
            wait_n(3); sclk = 1'b1;
            wait_n(3); sclk = 1'b0;
        end
        wait_n(3); sload = 1'b1;
        wait_n(3); sload = 1'b0;
        wait_n(4);
    endtask

    task automatic pulse_halt();
        @(negedge clk); halt = 1'b1;
        wait_n(3);
        halt = 1'b0;
    endtask

    task automatic measure(input int n, output int hc, output int lc);
        hc = 0; lc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hi_drv) hc++;
            if (lo_drv) lc++;
        end
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int hc, lc;
        // R1: outputs low while reset is held
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_val("R1 hi_drv in reset", int'(hi_drv), 0);
            check_val("R1 lo_drv in reset", int'(lo_drv), 0);
        end
        rst_n = 1'b1;

        // R2 R3 R4 R6: F=2^20 gives a tick every 16 clocks, period 256; D=8, T=4
        send_word(1 << 20, 8, 4);
        pulse_halt();
        wait_n(600);
        measure(256, hc, lc);
        check_val("R4 R6 hi count D8 T4", hc, 128 - 5);
        check_val("R4 R6 lo count D8 T4", lc, 128 - 5);

        // R7: reprogram without halt; change waits for the wrap (model checks timing)
        send_word(1 << 20, 0, 4);
        wait_n(700);
        measure(256, hc, lc);
        check_val("R4 R7 hi count D0", hc, 0);
        check_val("R4 R7 lo count D0", lc, 256);

        send_word(1 << 20, 15, 4);
        wait_n(700);
        measure(256, hc, lc);
        check_val("R4 hi count D15", hc, 256);
        check_val("R4 lo count D15", lc, 0);

        send_word(1 << 20, 1, 2);
        wait_n(700);
        measure(256, hc, lc);
        check_val("R4 R6 hi count D1 T2", hc, 16 - 3);
        check_val("R4 R6 lo count D1 T2", lc, 240 - 3);

        // R3: doubled frequency word halves the period to 128 clocks; T=0
        send_word(1 << 21, 8, 0);
        pulse_halt();
        wait_n(500);
        measure(128, hc, lc);
        check_val("R3 R6 hi count F2^21 T0", hc, 63);
        check_val("R3 R6 lo count F2^21 T0", lc, 63);

        send_word(1 << 20, 4, 10);
        wait_n(700);
        measure(256, hc, lc);
        check_val("R6 hi count D4 T10", hc, 64 - 11);
        check_val("R6 lo count D4 T10", lc, 192 - 11);

        // R8: halt forces both outputs low on the next edge and keeps them low
        @(negedge clk); halt = 1'b1;
        @(negedge clk);
        check_val("R8 hi after halt", int'(hi_drv), 0);
        check_val("R8 lo after halt", int'(lo_drv), 0);
        measure(40, hc, lc);
        check_val("R8 hi during halt", hc, 0);
        check_val("R8 lo during halt", lc, 0);
        halt = 1'b0;
        wait_n(300);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule